// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the software-visible control and status words for one DMA channel that feeds a storage bus controller. A host reaches four 32-bit words through a word index taken from byte-address bits [3:2], which gives a 16-byte window. Word 0 is the channel control/status word and word 1 is the transfer address. Words 2 and 3 are plain storage. No bus mastering or memory movement happens here.

Writes to the control word are rewritten before they are stored. A version code is forced into the top nibble. A bit-6 value is self-clearing. An all-zero write becomes a default value. Setting bit 7 sends a one-cycle reset request to the attached controller. Writing the address word marks the channel as loaded in the control word. The attached controller signals interrupt events with set and clear pulses. The block keeps the pending flag and drives the interrupt line. Software can drop that line by writing the control word with interrupt enable clear.

Top module: `dma_ctl_regs`

## Requirements
- R1: While the synchronous active-low reset is asserted, and on release, all four words read zero, `irq_o` is 0 and `ctl_reset_o` is 0.
- R2: `bus_word_addr` selects the word: 0 is control, 1 is address, 2 and 3 are plain storage. Words 2 and 3 read back exactly what was written. `bus_rdata` follows the selected word combinationally.
- R3: A control write with bit 7 set drives `ctl_reset_o` high for exactly the one cycle after the write edge. The stored word is the written value with bits [31:28] replaced by 4'hA, and bit 6 is kept as written.
- R4: A control write with bit 7 clear and bit 6 set stores the value with bit 6 cleared and bits [31:28] set to 4'hA.
- R5: A control write of 0x00000000 stores 0xA0000040.
- R6: Every control write stores 4'hA in bits [31:28], whatever the written top nibble was.
- R7: Any write to word 1 stores the value there. It also sets bit 26 (loaded) in the control word and leaves the other control bits unchanged.
- R8: An `ev_int_set` pulse sets control bit 0 (interrupt pending) and raises `irq_o` at the next edge.
- R9: An `ev_int_clr` pulse clears control bit 0 and lowers `irq_o` at the next edge. When both pulses arrive in the same cycle, the set wins.
- R10: A control write with bit 4 (interrupt enable) clear lowers `irq_o` at the next edge. A control write with bit 4 set leaves `irq_o` unchanged. Bit 8 (transfer writes to memory) is stored as written.
- R11: Reads have no side effects: repeated reads return the same value and change neither `irq_o` nor any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the selected word |
| bus_word_addr | input | 2 | Word index (byte-address bits [3:2]) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Selected word, combinational |
| ev_int_set | input | 1 | Interrupt event pulse from the controller |
| ev_int_clr | input | 1 | Interrupt acknowledge pulse from the controller |
| irq_o | output | 1 | Interrupt request line |
| ctl_reset_o | output | 1 | One-cycle reset request to the controller |

## Verification
A write or an event pulse takes effect at the clock edge that samples it. Stored words therefore appear on `bus_rdata` from that edge on, while the index is held. `irq_o` changes at that same edge. `ctl_reset_o` is high only in the cycle after a reset-bit write and low again one edge later. The driver applies each stimulus at a falling edge and queues every expected value with the number of the rising edge where it becomes due. The monitor compares it 5 ns after that edge, so no check reads a value before the register that produces it has updated.

// File: rtl/dma_ctl_pkg.sv
// Package dma_ctl_pkg
// Shared bit positions, word indices and the filtered-write record for the
// DMA channel control register block. Assumes a data width of at least 32.
package dma_ctl_pkg;

    // Control-word bit positions
    localparam int unsigned BIT_PEND    = 0;   // interrupt pending
    localparam int unsigned BIT_IE      = 4;   // interrupt enable
    localparam int unsigned BIT_SELFCLR = 6;   // self-clearing bit
    localparam int unsigned BIT_RESET   = 7;   // reset request
    localparam int unsigned BIT_TOMEM   = 8;   // transfer writes to memory
    localparam int unsigned BIT_LOADED  = 26;  // address word written

    // Word indices
    typedef enum logic [1:0] {
        IDX_CTRL = 2'd0,
        IDX_ADDR = 2'd1,
        IDX_AUX0 = 2'd2,
        IDX_AUX1 = 2'd3
    } word_idx_e;

    // Result of rewriting a control-word write
    typedef struct packed {
        logic [31:0] value;
        logic        rst_req;
    } ctrl_wr_t;

endpackage

// File: rtl/dma_ctl_wfilter.sv
// Module dma_ctl_wfilter
// Purely combinational rewrite of a value written to the control word:
// reset bit wins over the self-clearing rule, an all-zero write becomes the
// default, and the version code always replaces the top nibble.
// Assumes DATA_W >= 32 so every fixed bit position exists.
module dma_ctl_wfilter
    import dma_ctl_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter logic [3:0]  VER_CODE = 4'hA
) (
    input  logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] fval,
    output logic              rst_req
);

    localparam logic [DATA_W-1:0] ZERO_DEFAULT = DATA_W'(1) << BIT_SELFCLR;

    // Apply the write rules in priority order
    always_comb begin
        fval    = wval;
        rst_req = wval[BIT_RESET];
        if (!wval[BIT_RESET]) begin
            if (wval[BIT_SELFCLR]) begin
                fval[BIT_SELFCLR] = 1'b0;
            end else if (wval == '0) begin
                fval = ZERO_DEFAULT;
            end
        end
        fval[DATA_W-1 -: 4] = VER_CODE;
    end

endmodule

// File: rtl/dma_ctl_irq.sv
// Module dma_ctl_irq
// Holds the interrupt request line. A set event raises it; a clear event or
// a control write with interrupt enable clear drops it; set has priority.
module dma_ctl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic clr_ev,
    input  logic ie_drop,
    output logic irq_q
);

    // Interrupt line state with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (set_ev) begin
            irq_q <= 1'b1;
        end else if (clr_ev || ie_drop) begin
            irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dma_ctl_regfile.sv
// Module dma_ctl_regfile
// Storage for the channel words. Word 0 takes the filtered control value
// and the loaded / pending side effects; the others store writes verbatim.
// Assumes wr_sel is one-hot or zero.
module dma_ctl_regfile
    import dma_ctl_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_REGS-1:0]        wr_sel,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [DATA_W-1:0]          ctrl_fval,
    input  logic                       loaded_set,
    input  logic                       pend_set,
    input  logic                       pend_clr,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_word
        logic [DATA_W-1:0] word_q;

        if (gi == 0) begin : g_ctrl
            logic [DATA_W-1:0] word_d;

            // Next control value: write, then loaded flag, then pending flag
            always_comb begin
                word_d = wr_sel[gi] ? ctrl_fval : word_q;
                if (loaded_set) begin
                    word_d[BIT_LOADED] = 1'b1;
                end
                if (pend_set) begin
                    word_d[BIT_PEND] = 1'b1;
                end else if (pend_clr) begin
                    word_d[BIT_PEND] = 1'b0;
                end
            end

            // Control word register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else begin
                    word_q <= word_d;
                end
            end
        end else begin : g_plain
            // Plain storage word
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    word_q <= '0;
                end else if (wr_sel[gi]) begin
                    word_q <= wdata;
                end
            end
        end

        assign regs_flat[gi*DATA_W +: DATA_W] = word_q;
    end

endmodule

// File: rtl/dma_ctl_regs.sv
// Module dma_ctl_regs (top)
// DMA channel control register block: word decode, control-write rewrite,
// loaded flag on address write, interrupt line and reset request pulse.
// Assumes one access per cycle; reads are combinational and side-effect free.
module dma_ctl_regs
    import dma_ctl_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned NUM_REGS = 4,
    parameter logic [3:0]  VER_CODE = 4'hA
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_wr,
    input  logic [$clog2(NUM_REGS)-1:0] bus_word_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    input  logic                        ev_int_set,
    input  logic                        ev_int_clr,
    output logic                        irq_o,
    output logic                        ctl_reset_o
);

    localparam int unsigned IDX_W = $clog2(NUM_REGS);

    logic [NUM_REGS-1:0]        wr_sel;
    logic [DATA_W-1:0]          ctrl_fval;
    logic                       ctrl_rst_req;
    logic [NUM_REGS*DATA_W-1:0] regs_flat;
    logic [DATA_W-1:0]          ctrl_word;
    logic                       ctrl_wr;
    logic                       ie_drop;
    logic                       rst_pulse_q;

    // One-hot write select from the word index
    always_comb begin
        wr_sel = '0;
        if (bus_wr) begin
            wr_sel[bus_word_addr] = 1'b1;
        end
    end

    assign ctrl_wr = wr_sel[IDX_CTRL];
    assign ie_drop = ctrl_wr && !bus_wdata[BIT_IE];

    dma_ctl_wfilter #(
        .DATA_W   (DATA_W),
        .VER_CODE (VER_CODE)
    ) u_wfilter (
        .wval    (bus_wdata),
        .fval    (ctrl_fval),
        .rst_req (ctrl_rst_req)
    );

    dma_ctl_regfile #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_regfile (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_sel     (wr_sel),
        .wdata      (bus_wdata),
        .ctrl_fval  (ctrl_fval),
        .loaded_set (wr_sel[IDX_ADDR]),
        .pend_set   (ev_int_set),
        .pend_clr   (ev_int_clr),
        .regs_flat  (regs_flat)
    );

    dma_ctl_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_ev  (ev_int_set),
        .clr_ev  (ev_int_clr),
        .ie_drop (ie_drop),
        .irq_q   (irq_o)
    );

    // One-cycle reset request toward the controller
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pulse_q <= 1'b0;
        end else begin
            rst_pulse_q <= ctrl_wr && ctrl_rst_req;
        end
    end

    assign ctl_reset_o = rst_pulse_q;
    assign ctrl_word   = regs_flat[DATA_W-1:0];
    assign bus_rdata   = regs_flat[IDX_W'(bus_word_addr)*DATA_W +: DATA_W];

endmodule

// File: rtl/dma_ctl_regs_chk.sv
// Module dma_ctl_regs_chk
// Concurrent checks on dma_ctl_regs, attached with bind below.
module dma_ctl_regs_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [IDX_W-1:0]  bus_word_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              ev_int_set,
    input logic              ev_int_clr,
    input logic              irq_o,
    input logic              ctl_reset_o,
    input logic [DATA_W-1:0] ctrl_q
);

    logic wr_ctrl;
    logic wr_addr;
    assign wr_ctrl = bus_wr && (bus_word_addr == '0);
    assign wr_addr = bus_wr && (bus_word_addr == IDX_W'(1));

    p_rst_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[7]) |=> ctl_reset_o);

    p_rst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_ctrl && bus_wdata[7]) |=> !ctl_reset_o);

    p_version_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl |=> (ctrl_q[DATA_W-1 -: 4] == 4'hA));

    p_zero_default_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata == '0 && !ev_int_set)
            |=> (ctrl_q == (DATA_W'(32'hA000_0040))));

    p_loaded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr |=> ctrl_q[26]);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ev_int_set |=> (irq_o && ctrl_q[0]));

    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_int_clr && !ev_int_set) |=> !irq_o);

    p_ie_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !bus_wdata[4] && !ev_int_set) |=> !irq_o);

    p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_int_set && !ev_int_clr && !(wr_ctrl && !bus_wdata[4]))
            |=> $stable(irq_o));

endmodule

bind dma_ctl_regs dma_ctl_regs_chk #(
    .DATA_W (DATA_W),
    .IDX_W  ($clog2(NUM_REGS))
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_wr        (bus_wr),
    .bus_word_addr (bus_word_addr),
    .bus_wdata     (bus_wdata),
    .ev_int_set    (ev_int_set),
    .ev_int_clr    (ev_int_clr),
    .irq_o         (irq_o),
    .ctl_reset_o   (ctl_reset_o),
    .ctrl_q        (ctrl_word)
);

// File: tb/sim_dma_ctl_regs.sv
// Scoreboard bench for dma_ctl_regs: the driver queues expected values with
// their due edge, and the monitor compares them 5 ns after that edge.
module sim_dma_ctl_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_word_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        ev_int_set = 1'b0;
    logic        ev_int_clr = 1'b0;
    logic        irq_o;
    logic        ctl_reset_o;

    always #10 clk = ~clk;   // 50 MHz

    dma_ctl_regs u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_wr        (bus_wr),
        .bus_word_addr (bus_word_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .ev_int_set    (ev_int_set),
        .ev_int_clr    (ev_int_clr),
        .irq_o         (irq_o),
        .ctl_reset_o   (ctl_reset_o)
    );

    typedef struct {
        int          due;
        int          kind;   // 0 rdata, 1 irq, 2 reset request
        logic [31:0] val;
        string       req;
    } item_t;

    item_t sbq[$];
    int    cyc     = 0;
    int    cur_due = 0;
    int    checks  = 0;
    int    errors  = 0;
    bit    done    = 1'b0;

    // Monitor: pop and compare the items due at this edge
    initial begin
        item_t       it;
        logic [31:0] act;
        forever begin
            @(posedge clk);
            cyc++;
            #5;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                it = sbq.pop_front();
                case (it.kind)
                    0:       act = bus_rdata;
                    1:       act = {31'd0, irq_o};
                    default: act = {31'd0, ctl_reset_o};
                endcase
                checks++;
                if (act !== it.val) begin
                    errors++;
                    $display("FAIL %s kind %0d cycle %0d: actual 0x%08h expected 0x%08h",
                             it.req, it.kind, cyc, act, it.val);
                end
            end
        end
    end

    // Drive all inputs for one cycle, starting at a falling edge
    task automatic drive(input logic w, input logic [1:0] a, input logic [31:0] d,
                         input logic s, input logic c);
        @(negedge clk);
        bus_wr        = w;
        bus_word_addr = a;
        bus_wdata     = d;
        ev_int_set    = s;
        ev_int_clr    = c;
        cur_due       = cyc + 1;
    endtask

    task automatic expect_item(input int off, input int kind, input logic [31:0] v,
                               input string r);
        item_t it;
        it.due  = cur_due + off;
        it.kind = kind;
        it.val  = v;
        it.req  = r;
        sbq.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        drive(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] v, input string r);
        drive(1'b0, a, 32'd0, 1'b0, 1'b0);
        expect_item(0, 0, v, r);
    endtask

    // Watchdog
    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus
    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        rd(2'd0, 32'h0, "R1");
        expect_item(0, 1, 32'd0, "R1");
        expect_item(0, 2, 32'd0, "R1");
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd1, 32'h0, "R1");
        rd(2'd2, 32'h0, "R1");
        rd(2'd3, 32'h0, "R1");
        rd(2'd0, 32'h0, "R1");

        // R2: plain storage words and index decode
        wr(2'd2, 32'h1234_5678);
        wr(2'd3, 32'hCAFE_F00D);
        rd(2'd2, 32'h1234_5678, "R2");
        rd(2'd3, 32'hCAFE_F00D, "R2");
        rd(2'd0, 32'h0, "R2");

        // R7: address write sets loaded flag only
        wr(2'd1, 32'h0000_1000);
        rd(2'd1, 32'h0000_1000, "R7");
        rd(2'd0, 32'h0400_0000, "R7");

        // R5: zero write becomes default
        wr(2'd0, 32'h0);
        expect_item(1, 2, 32'd0, "R5");
        rd(2'd0, 32'hA000_0040, "R5");

        // R7/R10: other control bits kept when loaded flag set; bit 8 stored
        wr(2'd0, 32'h0000_0110);
        rd(2'd0, 32'hA000_0110, "R10");
        wr(2'd1, 32'h0000_2000);
        rd(2'd0, 32'hA400_0110, "R7");

        // R4: self-clearing bit
        wr(2'd0, 32'h1234_0150);
        expect_item(1, 2, 32'd0, "R4");
        rd(2'd0, 32'hA234_0110, "R4");

        // R3: reset bit wins, pulse lasts one cycle, bit 6 kept
        wr(2'd0, 32'h0000_00C1);
        expect_item(0, 2, 32'd1, "R3");
        expect_item(1, 2, 32'd0, "R3");
        rd(2'd0, 32'hA000_00C1, "R3");

        // R6: top nibble forced
        wr(2'd0, 32'hF000_0010);
        rd(2'd0, 32'hA000_0010, "R6");

        // R8: interrupt event
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
        expect_item(0, 1, 32'd1, "R8");
        rd(2'd0, 32'hA000_0011, "R8");

        // R10: enable set keeps the line, enable clear drops it
        wr(2'd0, 32'h0000_0010);
        expect_item(0, 1, 32'd1, "R10");
        rd(2'd0, 32'hA000_0010, "R10");
        wr(2'd0, 32'h0000_0100);
        expect_item(0, 1, 32'd0, "R10");
        rd(2'd0, 32'hA000_0100, "R10");

        // R9: clear event, then simultaneous set and clear
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b0);
        expect_item(0, 1, 32'd1, "R9");
        drive(1'b0, 2'd0, 32'd0, 1'b0, 1'b1);
        expect_item(0, 1, 32'd0, "R9");
        rd(2'd0, 32'hA000_0100, "R9");
        drive(1'b0, 2'd0, 32'd0, 1'b1, 1'b1);
        expect_item(0, 1, 32'd1, "R9");
        rd(2'd0, 32'hA000_0101, "R9");

        // R11: repeated reads change nothing
        rd(2'd0, 32'hA000_0101, "R11");
        rd(2'd0, 32'hA000_0101, "R11");
        expect_item(0, 1, 32'd1, "R11");
        rd(2'd3, 32'hCAFE_F00D, "R11");

        // R1: reset in mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        rd(2'd0, 32'h0, "R1");
        expect_item(0, 1, 32'd0, "R1");
        rd(2'd1, 32'h0, "R1");
        rd(2'd3, 32'h0, "R1");
        @(negedge clk);
        rst_n = 1'b1;

        drive(1'b0, 2'd0, 32'd0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule